// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block is the digital control core of a 12-bit serial sampling converter. It watches an active-low chip select, a frame-sync input and a host-driven serial clock, all three oversampled in a fast system clock. From these it decides when a frame begins, opens and closes the sampling window, and starts a conversion of fixed length timed in system-clock cycles. It also shifts the stored result out on a data pin with a separate output enable, and it drops into power-down whenever it is idle.

A frame may be started in three ways. Chip select can fall while frame sync is high. Frame sync can pulse while chip select is held low. Chip select can fall while frame sync is low, with the frame then starting on the next frame-sync falling edge. A stub converter supplies the result word, which is captured when a conversion completes. The data shifted out in any frame is therefore the sample from the frame before it.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, powerDown is 1 and sdoEn, busy, sampleOn and convStart are 0.
- R2: Chip-select mode: if frame sync is high when csN falls, the frame starts at once and sdoEn rises. The 16 bits shifted out are the held 12-bit result MSB first, followed by four 0 bits. Each bit changes after an SCLK rising edge and is read on the following SCLK falling edge, and the MSB is valid at the first falling edge.
- R3: Frame-sync mode: with csN held low, an fs rising edge raises sdoEn and presents the MSB. The frame, and its SCLK count, start on the next fs falling edge.
- R4: Combined mode: if fs is low when csN falls, sdoEn rises and the MSB is presented. SCLK edges before the next fs falling edge neither shift data nor open the sampling window.
- R5: sampleOn is high from the 4th SCLK falling edge of the frame until the 16th, which is a window of 12 SCLK periods.
- R6: At the 16th SCLK falling edge, sdoEn and sampleOn fall, busy rises, and convStart is high for exactly one system-clock cycle.
- R7: busy lasts CONV_CYCLES system-clock cycles. The block then returns to power-down and captures resultIn, and that value is shifted out in the next frame.
- R8: A csN or fs rising edge during a conversion aborts it. busy falls, powerDown rises, and the held result keeps its old value.
- R9: csN rising during a frame ends it. sdoEn falls, powerDown rises, and no conversion starts.
- R10: The result is straight binary. The codes 0x000 and 0xFFF are shifted out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync |
| sclk | input | 1 | Host serial clock |
| resultIn | input | 12 | Result word from the stub converter |
| sdoData | output | 1 | Serial data value |
| sdoEn | output | 1 | Drive enable for the serial data pin (0 = high impedance) |
| sampleOn | output | 1 | Sampling window open |
| convStart | output | 1 | One-cycle strobe at conversion start |
| busy | output | 1 | Conversion in progress |
| powerDown | output | 1 | Idle and powered down |

## Verification
Every pin change passes through two synchronizer flops and one compare flop, so its effect shows on the outputs at the third system-clock edge after the change. Conversion completion follows CONV_CYCLES edges after convStart. The bench holds each SCLK phase for eight system clocks. It reads serial data at the raw SCLK falling edge, which is at least eight cycles after the rising edge that shifted it. It reads the strobes five cycles after an edge, which is past the three-cycle latency and before the next edge. Completion is checked a few cycles after the conversion window is due to close, and aborts are checked five cycles after the rising edge that causes them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FRAME = 2'd2,
    ST_CONV  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadShift;
    logic shiftOut;
    logic latchResult;
  } dpStrobe_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinRaw,
  output logic [WIDTH-1:0] syncNow,
  output logic [WIDTH-1:0] syncPrev
);
  logic [WIDTH-1:0] metaQ;
  logic [WIDTH-1:0] stableQ;
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ   <= RST_VAL;
      stableQ <= RST_VAL;
      prevQ   <= RST_VAL;
    end else begin
      metaQ   <= pinRaw;
      stableQ <= metaQ;
      prevQ   <= stableQ;
    end
  end

  assign syncNow  = stableQ;
  assign syncPrev = prevQ;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS   = 16,
  parameter int SAMPLE_START = 4,
  parameter int SAMPLE_LEN   = 12,
  parameter int CONV_CYCLES  = 350
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csNow,
  input  logic      csPrev,
  input  logic      fsNow,
  input  logic      fsPrev,
  input  logic      sclkNow,
  input  logic      sclkPrev,
  output dpStrobe_t dpStrobe,
  output logic      sdoEn,
  output logic      sampleOn,
  output logic      convStart,
  output logic      busy,
  output logic      powerDown
);
  localparam int CNT_W  = $clog2(FRAME_BITS + 1);
  localparam int CONV_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]  WIN_OPEN   = CNT_W'(SAMPLE_START);
  localparam logic [CNT_W-1:0]  WIN_CLOSE  = CNT_W'(SAMPLE_START + SAMPLE_LEN);
  localparam logic [CONV_W-1:0] LAST_CONV  = CONV_W'(CONV_CYCLES - 1);

  seqState_t         state, stateNxt;
  logic [CNT_W-1:0]  sclkCnt, sclkCntNxt;
  logic [CONV_W-1:0] convCnt, convCntNxt;
  logic              convStartQ, startPulse;

  logic csFall, csRise, fsRise, fsFall, sclkRise, sclkFall;
  assign csFall   = csPrev & ~csNow;
  assign csRise   = ~csPrev & csNow;
  assign fsRise   = ~fsPrev & fsNow;
  assign fsFall   = fsPrev & ~fsNow;
  assign sclkRise = ~sclkPrev & sclkNow;
  assign sclkFall = sclkPrev & ~sclkNow;

  always_comb begin
    stateNxt   = state;
    sclkCntNxt = sclkCnt;
    convCntNxt = convCnt;
    dpStrobe   = '0;
    startPulse = 1'b0;
    case (state)
      ST_IDLE: begin
        if (csFall) begin
          dpStrobe.loadShift = 1'b1;
          sclkCntNxt         = '0;
          stateNxt           = fsNow ? ST_FRAME : ST_ARMED;
        end else if (fsRise && !csNow) begin
          dpStrobe.loadShift = 1'b1;
          stateNxt           = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (csRise) begin
          stateNxt = ST_IDLE;
        end else if (fsFall) begin
          sclkCntNxt = '0;
          stateNxt   = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (csRise) begin
          stateNxt = ST_IDLE;
        end else if (sclkFall) begin
          sclkCntNxt = sclkCnt + CNT_W'(1);
          if (sclkCnt == LAST_BIT) begin
            stateNxt   = ST_CONV;
            convCntNxt = '0;
            startPulse = 1'b1;
          end
        end else if (sclkRise && sclkCnt != '0) begin
          dpStrobe.shiftOut = 1'b1;
        end
      end
      ST_CONV: begin
        if (csRise || fsRise) begin
          stateNxt = ST_IDLE;
        end else if (convCnt == LAST_CONV) begin
          dpStrobe.latchResult = 1'b1;
          stateNxt             = ST_IDLE;
        end else begin
          convCntNxt = convCnt + CONV_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sclkCnt    <= '0;
      convCnt    <= '0;
      convStartQ <= 1'b0;
    end else begin
      state      <= stateNxt;
      sclkCnt    <= sclkCntNxt;
      convCnt    <= convCntNxt;
      convStartQ <= startPulse;
    end
  end

  assign sdoEn     = (state == ST_ARMED) || (state == ST_FRAME);
  assign sampleOn  = (state == ST_FRAME) && (sclkCnt >= WIN_OPEN) && (sclkCnt < WIN_CLOSE);
  assign busy      = (state == ST_CONV);
  assign powerDown = (state == ST_IDLE);
  assign convStart = convStartQ;
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStrobe,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoData
);
  localparam int PAD_W = FRAME_BITS - DATA_W;

  logic [DATA_W-1:0]     heldResult;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] loadWord;

  generate
    if (PAD_W > 0) begin : g_pad
      assign loadWord = {heldResult, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign loadWord = heldResult;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldResult <= '0;
      shiftReg   <= '0;
    end else begin
      if (dpStrobe.latchResult) heldResult <= resultIn;
      if (dpStrobe.loadShift) begin
        shiftReg <= loadWord;
      end else if (dpStrobe.shiftOut) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign sdoData = shiftReg[FRAME_BITS-1];
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int FRAME_BITS   = 16,
  parameter int SAMPLE_START = 4,
  parameter int SAMPLE_LEN   = 12,
  parameter int SYS_CLK_MHZ  = 100,
  parameter int CONV_NS      = 3500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              fs,
  input  logic              sclk,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoData,
  output logic              sdoEn,
  output logic              sampleOn,
  output logic              convStart,
  output logic              busy,
  output logic              powerDown
);
  localparam int CONV_CYCLES = SYS_CLK_MHZ * CONV_NS / 1000;

  logic [2:0] pinNow, pinPrev;
  dpStrobe_t  dpStrobe;

  adc_seq_sync #(.WIDTH(3), .RST_VAL(3'b011)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .pinRaw  ({sclk, fs, csN}),
    .syncNow (pinNow),
    .syncPrev(pinPrev)
  );

  adc_seq_ctrl #(
    .FRAME_BITS  (FRAME_BITS),
    .SAMPLE_START(SAMPLE_START),
    .SAMPLE_LEN  (SAMPLE_LEN),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csNow    (pinNow[0]),
    .csPrev   (pinPrev[0]),
    .fsNow    (pinNow[1]),
    .fsPrev   (pinPrev[1]),
    .sclkNow  (pinNow[2]),
    .sclkPrev (pinPrev[2]),
    .dpStrobe (dpStrobe),
    .sdoEn    (sdoEn),
    .sampleOn (sampleOn),
    .convStart(convStart),
    .busy     (busy),
    .powerDown(powerDown)
  );

  adc_seq_dpath #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .dpStrobe(dpStrobe),
    .resultIn(resultIn),
    .sdoData (sdoData)
  );
endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk (
  input logic clk,
  input logic rstN,
  input logic sdoEn,
  input logic sampleOn,
  input logic convStart,
  input logic busy,
  input logic powerDown
);
  // R1
  idle_vs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(powerDown && busy));

  // R6
  drive_vs_convert_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoEn && busy));

  // R5
  window_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleOn |-> sdoEn);

  // R6
  conv_start_on_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> convStart);

  // R6
  conv_start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R6
  conv_start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);
endmodule

bind adc_frame_seq adc_frame_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdoEn    (sdoEn),
  .sampleOn (sampleOn),
  .convStart(convStart),
  .busy     (busy),
  .powerDown(powerDown)
);

// File: tb/tb_adc_frame_seq.sv
`timescale 1ns/1ps
module tb_adc_frame_seq;
  localparam int CONV_CYCLES = 350;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic fs = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] resultIn = '0;
  logic sdoData, sdoEn, sampleOn, convStart, busy, powerDown;

  int checks = 0;
  int errors = 0;
  int convStarts = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  string curTag = "R2";
  bit expQ[$];

  always #5 clk = ~clk;

  adc_frame_seq dut (
    .clk(clk), .rstN(rstN), .csN(csN), .fs(fs), .sclk(sclk),
    .resultIn(resultIn), .sdoData(sdoData), .sdoEn(sdoEn),
    .sampleOn(sampleOn), .convStart(convStart), .busy(busy),
    .powerDown(powerDown)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (rstN && convStart) convStarts++;

  // Monitor: pops one expected bit per SCLK falling edge
  initial begin
    forever begin
      @(negedge sclk);
      if (monOn && expQ.size() > 0) begin
        bit e;
        e = expQ.pop_front();
        check(sdoEn === 1'b1 && sdoData === e, curTag, {sdoEn, sdoData}, {1'b1, e});
      end
    end
  end

  // Driver: queues the expected bits, then clocks nPulses SCLK periods
  task automatic runFrame(input logic [11:0] word, input int nPulses, input string tag);
    logic [15:0] frameWord;
    frameWord = {word, 4'b0000};
    curTag = tag;
    for (int b = 0; b < nPulses; b++) expQ.push_back(frameWord[15-b]);
    monOn = 1'b1;
    for (int i = 1; i <= nPulses; i++) begin
      sclk = 1'b1;
      cyc(HALF);
      sclk = 1'b0;
      cyc(5);
      check(sampleOn === ((i >= 4 && i < 16) ? 1'b1 : 1'b0), "R5", sampleOn, (i >= 4 && i < 16));
      if (i == 16) begin
        check(busy === 1'b1 && sdoEn === 1'b0, "R6", {busy, sdoEn}, 2'b10);
      end
      cyc(HALF - 5);
    end
    monOn = 1'b0;
  endtask

  initial begin
    int startsBefore;
    cyc(5);
    rstN = 1'b1;
    cyc(5);
    // R1 reset state
    check(powerDown === 1'b1 && sdoEn === 1'b0 && busy === 1'b0 && sampleOn === 1'b0 && convStart === 1'b0,
          "R1", {powerDown, sdoEn, busy, sampleOn, convStart}, 5'b10000);

    // Frame A: chip-select mode, shifts the reset value, converts 0xA5C (R2, R7)
    resultIn = 12'hA5C;
    fs = 1'b1;
    csN = 1'b0;
    cyc(6);
    check(sdoEn === 1'b1 && powerDown === 1'b0, "R2", {sdoEn, powerDown}, 2'b10);
    startsBefore = convStarts;
    runFrame(12'h000, 16, "R2");
    check(convStarts == startsBefore + 1, "R6", convStarts - startsBefore, 1);
    cyc(CONV_CYCLES + 10);
    check(busy === 1'b0 && powerDown === 1'b1, "R7", {busy, powerDown}, 2'b01);

    // Frame B: frame-sync mode with csN held low, shifts 0xA5C (R3, R7)
    fs = 1'b0;
    cyc(10);
    check(sdoEn === 1'b0, "R3", sdoEn, 0);
    resultIn = 12'hFFF;
    fs = 1'b1;
    cyc(6);
    check(sdoEn === 1'b1 && sdoData === 1'b1, "R3", {sdoEn, sdoData}, 2'b11);
    fs = 1'b0;
    cyc(6);
    runFrame(12'hA5C, 16, "R7");
    cyc(CONV_CYCLES + 10);
    check(powerDown === 1'b1, "R7", powerDown, 1);

    // Frame C: frame-sync mode, full-scale code, converts 0x000 (R10)
    resultIn = 12'h000;
    fs = 1'b1;
    cyc(6);
    fs = 1'b0;
    cyc(6);
    runFrame(12'hFFF, 16, "R10");
    cyc(CONV_CYCLES + 10);
    csN = 1'b1;
    cyc(10);
    check(powerDown === 1'b1 && sdoEn === 1'b0, "R1", {powerDown, sdoEn}, 2'b10);

    // Frame D: combined mode, leading SCLKs ignored, conversion aborted (R4, R8, R10)
    fs = 1'b0;
    cyc(10);
    resultIn = 12'h123;
    csN = 1'b0;
    cyc(6);
    check(sdoEn === 1'b1 && sdoData === 1'b0, "R4", {sdoEn, sdoData}, 2'b10);
    for (int p = 0; p < 5; p++) begin
      sclk = 1'b1; cyc(HALF);
      sclk = 1'b0; cyc(HALF);
    end
    check(sampleOn === 1'b0 && sdoEn === 1'b1, "R4", {sampleOn, sdoEn}, 2'b01);
    fs = 1'b1;
    cyc(HALF);
    fs = 1'b0;
    cyc(6);
    runFrame(12'h000, 16, "R10");
    cyc(20);
    csN = 1'b1;
    cyc(5);
    check(busy === 1'b0 && powerDown === 1'b1, "R8", {busy, powerDown}, 2'b01);
    cyc(CONV_CYCLES + 10);

    // Frame E: held result still 0x000 after abort; csN rises mid-frame (R8, R9)
    fs = 1'b1;
    cyc(10);
    csN = 1'b0;
    cyc(6);
    startsBefore = convStarts;
    runFrame(12'h000, 6, "R8");
    csN = 1'b1;
    cyc(5);
    check(sdoEn === 1'b0 && powerDown === 1'b1, "R9", {sdoEn, powerDown}, 2'b01);
    cyc(CONV_CYCLES + 10);
    check(convStarts == startsBefore && busy === 1'b0, "R9", convStarts - startsBefore, 0);

    check(expQ.size() == 0, "R2", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule